// File: doc/BRIEF.md
# Memory Power-Down and Power-Up Sequencer

This block sits on the host side of a low-power pseudo-static memory and owns the two chip-enable lines whenever the memory is not in ordinary use: the active-high enable (`mem_en_hi`) that puts the device into and out of its power-down state, and the active-low select (`mem_sel_n`) that must stay high during every recovery window. After reset it runs the power-up sequence. It then reports `mem_ready` and passes the select of an external access controller through to the memory. While ready, it takes a level request to power down. It waits until the access controller is idle before it acts on that request. On release it brings the device back and holds the select high for a recovery wait that depends on the retention mode in force when power-down began.

All waits are parameters in clock cycles. Programming the retention mode and issuing reads or writes are handled elsewhere. The sequencer only reports readiness and, while ready, forwards the access controller's select.

Top module: `lpmem_pwr_seq`

## Requirements
- R1: While `rst_n` is low, `mem_en_hi` is 0, `mem_sel_n` is 1 and `mem_ready` is 0.
- R2: After reset is released, `mem_en_hi` stays 0 for exactly `PWRUP_LOW_CYC` sampled cycles and then rises.
- R3: After the power-up rise of `mem_en_hi`, `mem_ready` rises after exactly `SLEEP_EXIT_CYC` cycles, whatever the value of `retain_sel`.
- R4: When `mem_ready`, `pd_req` and `acc_idle` are all 1 at a clock edge, `mem_ready` falls at that edge. `mem_en_hi` falls after exactly `ENTRY_SETUP_CYC` further cycles.
- R5: While `acc_idle` is 0, a raised `pd_req` has no effect: `mem_ready` and `mem_en_hi` stay 1.
- R6: Once `mem_en_hi` has fallen for power-down, it stays 0 for at least `ENTRY_HOLD_CYC` cycles. It also stays 0 as long as `pd_req` is 1. It rises only at an edge where `pd_req` is 0.
- R7: After a power-down exit, `mem_ready` rises exactly `PARTIAL_EXIT_CYC` cycles after `mem_en_hi` rises if `retain_sel` was 1 (partial retention) at the edge where `mem_en_hi` fell. It rises after `SLEEP_EXIT_CYC` cycles if `retain_sel` was 0 (sleep). Changes of `retain_sel` during power-down have no effect.
- R8: `mem_sel_n` is 1 whenever `mem_ready` is 0, including the cycles before and at every rise of `mem_en_hi`. While `mem_ready` is 1, `mem_sel_n` equals `acc_sel_n`.
- R9: A `pd_req` held at 1 during a recovery wait does not shorten or stretch that wait. It is acted on only once `mem_ready` has risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; releasing it starts power-up |
| pd_req | input | 1 | Level request: 1 = enter or stay in power-down |
| retain_sel | input | 1 | 1 = a partial-retention mode is programmed, 0 = sleep |
| acc_idle | input | 1 | Access controller has no read or write in progress |
| acc_sel_n | input | 1 | Access controller's active-low select, forwarded while ready |
| mem_en_hi | output | 1 | Active-high power enable line of the memory |
| mem_sel_n | output | 1 | Active-low select line of the memory |
| mem_ready | output | 1 | Memory may be accessed |

## Verification
Two functions of the block can meet in one cycle. The first is the end of a recovery wait. The second is a power-down request that has been pending since before the device came back. The bench provokes this by raising `pd_req` in the cycle after `mem_en_hi` rises and holding it through the whole wait. It then judges that the wait still has its exact length and that `mem_ready` is high for exactly one cycle before entry begins again. A second meeting point is a request that arrives while the access controller is busy. There the bench checks that readiness and the enable line are untouched until `acc_idle` returns.

// File: rtl/lpmem_pwr_pkg.sv
package lpmem_pwr_pkg;

  typedef enum logic [2:0] {
    S_INIT_LOW = 3'd0,
    S_WAKE     = 3'd1,
    S_READY    = 3'd2,
    S_SETUP    = 3'd3,
    S_DOWN     = 3'd4
  } pwr_state_e;

  // recovery wait after the enable line rises, chosen by the retention mode
  function automatic int unsigned wake_cycles(input logic keep,
                                              input int unsigned sleep_c,
                                              input int unsigned part_c);
    return keep ? part_c : sleep_c;
  endfunction

  // value loaded into a down counter so that a state lasts n cycles
  function automatic int unsigned span_load(input int unsigned n);
    return (n == 0) ? 0 : n - 1;
  endfunction

  function automatic int unsigned max5(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d,
                                       input int unsigned e);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction

endpackage

// File: rtl/lpmem_pwr_timer.sv
module lpmem_pwr_timer #(
  parameter int unsigned CW = 8,
  parameter logic [CW-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= INIT;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // once expired the timer stays expired until reloaded
  AST_TMR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !load) |=> done); // R6

endmodule

// File: rtl/lpmem_pwr_fsm.sv
module lpmem_pwr_fsm
  import lpmem_pwr_pkg::*;
#(
  parameter int unsigned CW               = 8,
  parameter int unsigned SLEEP_EXIT_CYC   = 100,
  parameter int unsigned PARTIAL_EXIT_CYC = 7,
  parameter int unsigned ENTRY_SETUP_CYC  = 1,
  parameter int unsigned ENTRY_HOLD_CYC   = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_req,
  input  logic          retain_sel,
  input  logic          acc_idle,
  input  logic          tmr_done,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          en_hi,
  output logic          ready
);
  pwr_state_e st, nxt;
  logic       keep_mode;

  // named events for the assertions
  logic entry_go;   // accepted power-down request
  logic down_go;    // enable line falls at this edge
  logic exit_go;    // enable line rises at this edge
  logic wake_done;  // recovery wait over
  logic pu_done;    // power-up low phase over

  assign entry_go  = (st == S_READY)    && pd_req && acc_idle;
  assign down_go   = (st == S_SETUP)    && tmr_done;
  assign exit_go   = (st == S_DOWN)     && tmr_done && !pd_req;
  assign wake_done = (st == S_WAKE)     && tmr_done;
  assign pu_done   = (st == S_INIT_LOW) && tmr_done;

  always_comb begin
    nxt      = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (st)
      S_INIT_LOW: if (pu_done) begin
        nxt = S_WAKE; tmr_load = 1'b1; tmr_val = CW'(span_load(SLEEP_EXIT_CYC));
      end
      S_WAKE: if (wake_done) nxt = S_READY;
      S_READY: if (entry_go) begin
        nxt = S_SETUP; tmr_load = 1'b1; tmr_val = CW'(span_load(ENTRY_SETUP_CYC));
      end
      S_SETUP: if (down_go) begin
        nxt = S_DOWN; tmr_load = 1'b1; tmr_val = CW'(span_load(ENTRY_HOLD_CYC));
      end
      S_DOWN: if (exit_go) begin
        nxt = S_WAKE; tmr_load = 1'b1;
        tmr_val = CW'(span_load(wake_cycles(keep_mode, SLEEP_EXIT_CYC, PARTIAL_EXIT_CYC)));
      end
      default: nxt = S_INIT_LOW;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_INIT_LOW;
      keep_mode <= 1'b0;
    end else begin
      st <= nxt;
      if (down_go) keep_mode <= retain_sel;
    end
  end

  assign en_hi = !((st == S_INIT_LOW) || (st == S_DOWN));
  assign ready = (st == S_READY);

  AST_DEFER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && pd_req && !acc_idle) |=> ready); // R5
  AST_DOWN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_DOWN) && pd_req) |=> (st == S_DOWN)); // R6
  AST_SETUP_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_SETUP) && !tmr_done) |=> (st == S_SETUP)); // R4
  AST_WAKE_TIMED: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_WAKE) && !tmr_done) |=> (st == S_WAKE && !ready)); // R7
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_DOWN) && $past(st == S_DOWN)) |-> $stable(keep_mode)); // R7
  AST_NO_EARLY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_WAKE) && pd_req) |=> !(st == S_SETUP)); // R9

endmodule

// File: rtl/lpmem_pwr_seq.sv
module lpmem_pwr_seq
  import lpmem_pwr_pkg::*;
#(
  parameter int unsigned PWRUP_LOW_CYC    = 5000,
  parameter int unsigned SLEEP_EXIT_CYC   = 30000,
  parameter int unsigned PARTIAL_EXIT_CYC = 7,
  parameter int unsigned ENTRY_SETUP_CYC  = 1,
  parameter int unsigned ENTRY_HOLD_CYC   = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req,
  input  logic retain_sel,
  input  logic acc_idle,
  input  logic acc_sel_n,
  output logic mem_en_hi,
  output logic mem_sel_n,
  output logic mem_ready
);
  localparam int unsigned MAXV = max5(PWRUP_LOW_CYC, SLEEP_EXIT_CYC, PARTIAL_EXIT_CYC,
                                      ENTRY_SETUP_CYC, ENTRY_HOLD_CYC);
  localparam int unsigned CW = (MAXV < 2) ? 1 : $clog2(MAXV + 1);
  localparam logic [CW-1:0] TMR_INIT = CW'(span_load(PWRUP_LOW_CYC));

  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_done;
  logic          en_hi_w;
  logic          ready_w;

  lpmem_pwr_timer #(.CW(CW), .INIT(TMR_INIT)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  lpmem_pwr_fsm #(
    .CW               (CW),
    .SLEEP_EXIT_CYC   (SLEEP_EXIT_CYC),
    .PARTIAL_EXIT_CYC (PARTIAL_EXIT_CYC),
    .ENTRY_SETUP_CYC  (ENTRY_SETUP_CYC),
    .ENTRY_HOLD_CYC   (ENTRY_HOLD_CYC)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pd_req     (pd_req),
    .retain_sel (retain_sel),
    .acc_idle   (acc_idle),
    .tmr_done   (tmr_done),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .en_hi      (en_hi_w),
    .ready      (ready_w)
  );

  assign mem_en_hi = en_hi_w;
  assign mem_ready = ready_w;
  assign mem_sel_n = ready_w ? acc_sel_n : 1'b1;

  AST_SEL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ready |-> mem_sel_n); // R8
  AST_RISE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_en_hi) |-> (mem_sel_n && $past(mem_sel_n))); // R8
  AST_FALL_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_en_hi) |-> ($past(mem_sel_n) && !$past(mem_ready))); // R4

endmodule

// File: tb/tb_lpmem_pwr_seq.sv
`timescale 1ns/1ps
module tb_lpmem_pwr_seq;
  localparam int unsigned P_LOW   = 40;
  localparam int unsigned P_SLEEP = 120;
  localparam int unsigned P_PART  = 7;
  localparam int unsigned P_SETUP = 3;
  localparam int unsigned P_HOLD  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_req = 1'b0;
  logic retain_sel = 1'b1;
  logic acc_idle = 1'b1;
  logic acc_sel_n = 1'b1;
  logic mem_en_hi, mem_sel_n, mem_ready;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  lpmem_pwr_seq #(
    .PWRUP_LOW_CYC(P_LOW), .SLEEP_EXIT_CYC(P_SLEEP), .PARTIAL_EXIT_CYC(P_PART),
    .ENTRY_SETUP_CYC(P_SETUP), .ENTRY_HOLD_CYC(P_HOLD)
  ) dut (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .retain_sel(retain_sel),
    .acc_idle(acc_idle), .acc_sel_n(acc_sel_n),
    .mem_en_hi(mem_en_hi), .mem_sel_n(mem_sel_n), .mem_ready(mem_ready)
  );

  function automatic int exp_wait(input bit first, input bit mode);
    if (first) return P_SLEEP;
    return mode ? P_PART : P_SLEEP;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  // ---------------- monitor on output runs ----------------
  logic pd_at_edge = 1'b0;
  always @(posedge clk) pd_at_edge <= pd_req;

  bit p_en = 1'b0, p_rdy = 1'b0, first_up = 1'b1, ent_mode = 1'b0;
  int lo_run = 0, hi_wait = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ready) check(mem_sel_n == 1'b1, "R8", mem_sel_n, 1);
      else            check(mem_sel_n == acc_sel_n, "R8", mem_sel_n, acc_sel_n);
      if (mem_en_hi && !p_en) begin
        if (first_up) check(lo_run == P_LOW, "R2", lo_run, P_LOW);
        else begin
          check(lo_run >= P_HOLD, "R6", lo_run, P_HOLD);
          check(pd_at_edge == 1'b0, "R6", pd_at_edge, 0);
        end
        lo_run  = 0;
        hi_wait = 1;
      end else if (!mem_en_hi && p_en) begin
        check(hi_wait == P_SETUP, "R4", hi_wait, P_SETUP);
        ent_mode = retain_sel;
        lo_run = 1;
        hi_wait = 0;
      end else if (!mem_en_hi) begin
        lo_run++;
      end else if (!mem_ready) begin
        if (p_rdy) hi_wait = 1;
        else       hi_wait++;
      end
      if (mem_ready && !p_rdy) begin
        check(hi_wait == exp_wait(first_up, ent_mode), first_up ? "R3" : "R7",
              hi_wait, exp_wait(first_up, ent_mode));
        first_up = 1'b0;
      end
      p_en  = mem_en_hi;
      p_rdy = mem_ready;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  task automatic step();
    @(posedge clk); #2;
    acc_sel_n = 1'($urandom);
  endtask

  task automatic wait_ready(input string req);
    int k = 0;
    while (!mem_ready && k < 2000) begin step(); k++; end
    @(negedge clk);
    check(mem_ready == 1'b1, req, mem_ready, 1);
  endtask

  task automatic wait_low(input string req);
    int k = 0;
    while (mem_en_hi && k < 2000) begin step(); k++; end
    @(negedge clk);
    check(mem_en_hi == 1'b0, req, mem_en_hi, 0);
  endtask

  task automatic wait_high(input string req);
    int k = 0;
    while (!mem_en_hi && k < 2000) begin step(); k++; end
    @(negedge clk);
    check(mem_en_hi == 1'b1, req, mem_en_hi, 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(mem_en_hi == 1'b0, "R1", mem_en_hi, 0);
    check(mem_sel_n == 1'b1, "R1", mem_sel_n, 1);
    check(mem_ready == 1'b0, "R1", mem_ready, 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    wait_ready("R3");   // retain_sel=1 during power-up must not shorten the wait

    for (int it = 0; it < 16; it++) begin
      pd_req = 1'b0;
      repeat (2 + $urandom % 6) step();
      retain_sel = 1'($urandom);
      if (it % 4 == 0) begin
        acc_idle = 1'b0;
        pd_req   = 1'b1;
        for (int j = 0; j < 6; j++) begin
          step();
          @(negedge clk);
          check(mem_ready == 1'b1 && mem_en_hi == 1'b1, "R5", {mem_ready, mem_en_hi}, 3);
        end
        step();
        acc_idle = 1'b1;
      end else begin
        pd_req = 1'b1;
      end
      wait_low("R4");
      // hold request a random time, flipping the mode input meanwhile (R7)
      for (int j = 0; j < int'($urandom % 12); j++) begin
        step();
        if (j >= 1) retain_sel = 1'($urandom);
      end
      step();
      pd_req = 1'b0;
      wait_high("R6");
      if (it % 3 == 1) begin
        step();
        pd_req = 1'b1;   // pending request across the whole recovery wait (R9)
        wait_low("R9");
        repeat (2) step();
        pd_req = 1'b0;
        wait_high("R9");
      end
      wait_ready("R7");
    end
    repeat (4) step();
    summary();
  end
endmodule